// File: doc/BRIEF.md
# Cut-Through Forwarding Controller

This block serves one ingress path of a small multi-port switch. It accepts a frame as a byte stream and stores every byte in a buffer sized for one maximum frame. Once the six destination address bytes are in, it looks the address up in a small table that maps stations to ports. It then picks the egress ports and decides how to forward the frame. If none of the chosen ports is busy, the frame leaves at once in cut-through mode, while its tail is still arriving. If any chosen port is busy, the frame is held until its last byte is in and the ports are free. A held frame is then sent whole.

The checksum result arrives with the final byte, so a cut-through frame cannot be recalled. If it turns out corrupt, the block marks the last output byte with an abort flag, and downstream logic discards the frame. A held frame that is found corrupt is never sent.

The address table learns from two sources: the source address of frames on this path, and learn requests from the other ingress paths of the switch. When the table is full, a round-robin pointer picks the entry to replace.

Top module: `cut_fwd_ctrl`

## Requirements
- R1: A destination address found in the table forwards the frame to that entry's port only: out_port_mask has exactly that bit set.
- R2: The all-ones destination address and any address missing from the table go to every port except INGRESS_PORT. The bit of INGRESS_PORT is never set in out_port_mask.
- R3: The forwarding decision is taken in the cycle after the sixth byte (destination address, first byte most significant) is accepted. If no selected port has port_busy high in that cycle, output starts before the frame's last byte is accepted.
- R4: If a selected port is busy at the decision, no byte leaves until the whole frame has arrived. Output then starts on the first cycle with all selected ports idle, and out_valid rises two clock edges after that cycle.
- R5: Output bytes match the input bytes in order. out_sof marks only the first byte and out_eof only the last. out_port_mask stays constant for the whole frame.
- R6: A cut-through frame whose in_crc_err is high with its last byte is delivered in full, with out_abort high together with out_eof.
- R7: A held frame whose in_crc_err is high with its last byte produces no output.
- R8: in_ready falls after the last byte of a frame is accepted and rises again once that frame has left or has been dropped. A frame that ends within its first five bytes is dropped with no output.
- R9: A frame whose only selected port is INGRESS_PORT is dropped with no output.
- R10: For a frame of at least 12 bytes, bytes 7 to 12 form the source address. If its group bit (bit 0 of its first byte) is clear, the table maps this address to INGRESS_PORT. If the group bit is set, nothing is learned.
- R11: A learn request on lrn_valid stores lrn_addr with lrn_port. The entry that already holds the address is rewritten; otherwise the lowest free entry is used; with the table full, the round-robin pointer entry is replaced, starting at entry 0 and advancing by one per replacement. A request in the same cycle as a local learn is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Ingress byte valid |
| in_data | input | 8 | Ingress byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_crc_err | input | 1 | Checksum failed, valid with in_eof |
| in_ready | output | 1 | Block accepts an ingress byte |
| port_busy | input | NPORTS | Egress port currently sending |
| lrn_valid | input | 1 | Learn request from a peer ingress path |
| lrn_addr | input | 48 | Address to learn |
| lrn_port | input | PW | Port of that address |
| out_valid | output | 1 | Egress byte valid |
| out_data | output | 8 | Egress byte |
| out_sof | output | 1 | First egress byte of a frame |
| out_eof | output | 1 | Last egress byte of a frame |
| out_abort | output | 1 | Late checksum error on a cut-through frame |
| out_port_mask | output | NPORTS | Egress ports selected for the byte |

## Verification
On every cycle, the assertions check these properties: the ingress port never appears in the output mask, no byte leaves while a frame is held, abort only comes with the last byte, and the mask holds steady within a frame. They also check that the buffer neither overruns nor reads empty, and that a lookup hits at most one table entry. Only the bench scenarios can show the rest: that cut-through output starts ahead of the frame's end, that a held frame starts on the exact cycle after the ports clear, that bytes arrive intact, and which entries learning and round-robin replacement overwrite.

// File: rtl/cf_pkg.sv
package cf_pkg;
  localparam int unsigned MAC_W = 48;
  typedef enum logic [1:0] {RX_IDLE, RX_BODY, RX_WAIT} rx_st_e;
  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_HOLD, TX_DROP} tx_st_e;
endpackage

// File: rtl/cf_addr_table.sv
module cf_addr_table #(
  parameter int ENTRIES = 8,
  parameter int NPORTS  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [cf_pkg::MAC_W-1:0]    lk_addr,
  output logic                        lk_hit,
  output logic [((NPORTS>1)?$clog2(NPORTS):1)-1:0] lk_port,
  input  logic                        up_valid,
  input  logic [cf_pkg::MAC_W-1:0]    up_addr,
  input  logic [((NPORTS>1)?$clog2(NPORTS):1)-1:0] up_port
);
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int EW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]        vld_q, vld_d;
  logic [cf_pkg::MAC_W-1:0]  mac_q [ENTRIES];
  logic [PW-1:0]             prt_q [ENTRIES];
  logic [EW-1:0]             rr_q, rr_d;
  logic [ENTRIES-1:0]        lk_match, up_match;
  logic [EW-1:0]             free_idx, match_idx, wr_idx;
  logic                      has_free;

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
    assign lk_match[gi] = vld_q[gi] && (mac_q[gi] == lk_addr);
    assign up_match[gi] = vld_q[gi] && (mac_q[gi] == up_addr);
  end

  always_comb begin
    lk_port = '0;
    for (int i = 0; i < ENTRIES; i++)
      lk_port = lk_port | (lk_match[i] ? prt_q[i] : '0);
  end
  assign lk_hit = |lk_match;

  // Next-state: pick the slot for an update
  always_comb begin
    free_idx  = '0;
    match_idx = '0;
    has_free  = 1'b0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_idx = EW'(i);
        has_free = 1'b1;
      end
      if (up_match[i]) match_idx = EW'(i);
    end
    rr_d = rr_q;
    if (|up_match)      wr_idx = match_idx;
    else if (has_free)  wr_idx = free_idx;
    else begin
      wr_idx = rr_q;
      if (up_valid) rr_d = (rr_q == EW'(ENTRIES-1)) ? '0 : rr_q + 1'b1;
    end
    vld_d = vld_q;
    if (up_valid) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (up_valid) begin
      mac_q[wr_idx] <= up_addr;
      prt_q[wr_idx] <= up_port;
    end
  end

  // R11: updates rewrite a matching entry, so a lookup never hits twice
  assert_unique_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
endmodule

// File: rtl/cf_frame_buf.sv
module cf_frame_buf #(
  parameter int DEPTH = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       wr_en,
  input  logic [8:0] wr_data,
  input  logic       rd_en,
  output logic [8:0] rd_data,
  output logic       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [8:0]    mem [DEPTH];
  logic [CW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d, wa;

  always_comb begin
    wa       = clr ? '0 : wr_ptr_q;
    wr_ptr_d = wr_en ? wa + 1'b1 : wa;
    rd_ptr_d = clr ? '0 : (rd_en ? rd_ptr_q + 1'b1 : rd_ptr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wa[AW-1:0]] <= wr_data;
  end

  assign rd_data = mem[rd_ptr_q[AW-1:0]];
  assign empty   = (rd_ptr_q == wr_ptr_q);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |-> (wr_ptr_q < CW'(DEPTH)));
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);
endmodule

// File: rtl/cf_port_select.sv
module cf_port_select #(
  parameter int NPORTS       = 4,
  parameter int INGRESS_PORT = 0
) (
  input  logic                 hit,
  input  logic [((NPORTS>1)?$clog2(NPORTS):1)-1:0] hit_port,
  input  logic                 bcast,
  output logic [NPORTS-1:0]    mask
);
  localparam logic [NPORTS-1:0] SELF = NPORTS'(1) << INGRESS_PORT;

  logic [NPORTS-1:0] base;
  always_comb begin
    if (bcast || !hit) base = '1;
    else               base = NPORTS'(1) << hit_port;
    mask = base & ~SELF;
  end
endmodule

// File: rtl/cut_fwd_ctrl.sv
module cut_fwd_ctrl #(
  parameter int NPORTS       = 4,
  parameter int INGRESS_PORT = 0,
  parameter int ENTRIES      = 8,
  parameter int MAX_FRAME    = 1518
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [7:0]          in_data,
  input  logic                in_sof,
  input  logic                in_eof,
  input  logic                in_crc_err,
  output logic                in_ready,
  input  logic [NPORTS-1:0]   port_busy,
  input  logic                lrn_valid,
  input  logic [47:0]         lrn_addr,
  input  logic [((NPORTS>1)?$clog2(NPORTS):1)-1:0] lrn_port,
  output logic                out_valid,
  output logic [7:0]          out_data,
  output logic                out_sof,
  output logic                out_eof,
  output logic                out_abort,
  output logic [NPORTS-1:0]   out_port_mask
);
  import cf_pkg::*;
  localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int DEPTH = 2 ** $clog2(MAX_FRAME);

  rx_st_e rx_q, rx_d;
  tx_st_e tx_q, tx_d;
  logic [3:0]        hcnt_q, hcnt_d, idx;
  logic [MAC_W-1:0]  da_q, da_d, sa_q, sa_d;
  logic              da_done_q, da_done_d, sa_done_q, sa_done_d;
  logic              eof_q, eof_d, crc_q, crc_d, cut_q, cut_d, first_q, first_d;
  logic [NPORTS-1:0] mask_q, mask_d, sel_mask;
  logic              acc, is_start, frame_byte, rd_en, tx_done, buf_empty;
  logic [8:0]        rd_word;
  logic              lk_hit, loc_learn, up_valid;
  logic [PW-1:0]     lk_port, up_port;
  logic [MAC_W-1:0]  up_addr;
  logic              ov_d, osof_d, oeof_d, oab_d;
  logic [7:0]        od_d;
  logic [NPORTS-1:0] omask_d;

  assign in_ready   = (rx_q != RX_WAIT);
  assign acc        = in_valid && in_ready;
  assign is_start   = acc && (rx_q == RX_IDLE) && in_sof;
  assign frame_byte = is_start || (acc && (rx_q == RX_BODY));
  assign idx        = is_start ? 4'd0 : hcnt_q;

  // Learning: local source address has priority over peer requests
  assign loc_learn = sa_done_q && !sa_q[40];
  assign up_valid  = loc_learn || lrn_valid;
  assign up_addr   = loc_learn ? sa_q : lrn_addr;
  assign up_port   = loc_learn ? PW'(INGRESS_PORT) : lrn_port;

  cf_addr_table #(.ENTRIES(ENTRIES), .NPORTS(NPORTS)) table_i (
    .clk(clk), .rst_n(rst_n), .lk_addr(da_q), .lk_hit(lk_hit), .lk_port(lk_port),
    .up_valid(up_valid), .up_addr(up_addr), .up_port(up_port));

  cf_port_select #(.NPORTS(NPORTS), .INGRESS_PORT(INGRESS_PORT)) sel_i (
    .hit(lk_hit), .hit_port(lk_port), .bcast(&da_q), .mask(sel_mask));

  cf_frame_buf #(.DEPTH(DEPTH)) buf_i (
    .clk(clk), .rst_n(rst_n), .clr(is_start), .wr_en(frame_byte),
    .wr_data({in_eof, in_data}), .rd_en(rd_en), .rd_data(rd_word), .empty(buf_empty));

  // Ingress next-state
  always_comb begin
    rx_d = rx_q;  hcnt_d = hcnt_q;  da_d = da_q;  sa_d = sa_q;
    eof_d = eof_q;  crc_d = crc_q;
    da_done_d = frame_byte && (idx == 4'd5);
    sa_done_d = frame_byte && (idx == 4'd11);
    if (frame_byte) begin
      hcnt_d = (idx == 4'd12) ? 4'd12 : idx + 4'd1;
      if (idx < 4'd6)       da_d = {da_q[MAC_W-9:0], in_data};
      else if (idx < 4'd12) sa_d = {sa_q[MAC_W-9:0], in_data};
      if (is_start) begin
        eof_d = 1'b0;
        crc_d = 1'b0;
        rx_d  = RX_BODY;
      end
      if (in_eof) begin
        eof_d = 1'b1;
        crc_d = in_crc_err;
        rx_d  = (idx < 4'd5) ? RX_IDLE : RX_WAIT;
      end
    end
    if ((rx_q == RX_WAIT) && tx_done) rx_d = RX_IDLE;
  end

  // Egress next-state
  always_comb begin
    tx_d = tx_q;  mask_d = mask_q;  cut_d = cut_q;  first_d = first_q;
    rd_en = 1'b0;  tx_done = 1'b0;
    case (tx_q)
      TX_IDLE: if (da_done_q) begin
        mask_d = sel_mask;
        if (sel_mask == '0)                 tx_d = TX_DROP;
        else if (|(sel_mask & port_busy))   tx_d = TX_HOLD;
        else begin
          tx_d = TX_SEND;  cut_d = 1'b1;  first_d = 1'b1;
        end
      end
      TX_SEND: begin
        rd_en = !buf_empty;
        if (rd_en) first_d = 1'b0;
        if (rd_en && rd_word[8]) begin
          tx_d = TX_IDLE;  tx_done = 1'b1;
        end
      end
      TX_HOLD: if (eof_q) begin
        if (crc_q) begin
          tx_d = TX_IDLE;  tx_done = 1'b1;
        end else if (!(|(mask_q & port_busy))) begin
          tx_d = TX_SEND;  cut_d = 1'b0;  first_d = 1'b1;
        end
      end
      default: if (eof_q) begin
        tx_d = TX_IDLE;  tx_done = 1'b1;
      end
    endcase
    ov_d    = rd_en;
    od_d    = rd_word[7:0];
    osof_d  = rd_en && first_q;
    oeof_d  = rd_en && rd_word[8];
    oab_d   = oeof_d && cut_q && crc_q;
    omask_d = rd_en ? mask_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= RX_IDLE;  tx_q <= TX_IDLE;  hcnt_q <= '0;
      da_q <= '0;  sa_q <= '0;  da_done_q <= 1'b0;  sa_done_q <= 1'b0;
      eof_q <= 1'b0;  crc_q <= 1'b0;  cut_q <= 1'b0;  first_q <= 1'b0;
      mask_q <= '0;
      out_valid <= 1'b0;  out_data <= '0;  out_sof <= 1'b0;  out_eof <= 1'b0;
      out_abort <= 1'b0;  out_port_mask <= '0;
    end else begin
      rx_q <= rx_d;  tx_q <= tx_d;  hcnt_q <= hcnt_d;
      da_q <= da_d;  sa_q <= sa_d;  da_done_q <= da_done_d;  sa_done_q <= sa_done_d;
      eof_q <= eof_d;  crc_q <= crc_d;  cut_q <= cut_d;  first_q <= first_d;
      mask_q <= mask_d;
      out_valid <= ov_d;  out_data <= od_d;  out_sof <= osof_d;  out_eof <= oeof_d;
      out_abort <= oab_d;  out_port_mask <= omask_d;
    end
  end

  assert_mask_excl_ingress_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!out_port_mask[INGRESS_PORT] && (out_port_mask != '0)));
  assert_hold_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_q == TX_HOLD) |=> !out_valid);
  assert_abort_eof_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_abort |-> (out_valid && out_eof));
  assert_mask_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eof) |=> (!out_valid || $stable(out_port_mask)));
endmodule

// File: tb/cut_fwd_ctrl_tb_top.sv
`timescale 1ns/1ps
module cut_fwd_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sof, in_eof, in_crc_err, in_ready;
  logic [7:0] in_data;
  logic [3:0] port_busy;
  logic lrn_valid;
  logic [47:0] lrn_addr;
  logic [1:0] lrn_port;
  logic out_valid, out_sof, out_eof, out_abort;
  logic [7:0] out_data;
  logic [3:0] out_port_mask;

  always #4 clk = ~clk;

  cut_fwd_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_crc_err(in_crc_err), .in_ready(in_ready),
    .port_busy(port_busy), .lrn_valid(lrn_valid), .lrn_addr(lrn_addr),
    .lrn_port(lrn_port), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_abort(out_abort),
    .out_port_mask(out_port_mask));

  int nchk = 0, nbad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Output monitor, samples 1 ns after each rising edge
  int mon_cnt, mon_first, mon_eofs;
  logic [7:0] mon_data [256];
  logic [3:0] mon_mask;
  logic mon_abort, mon_sof_ok, mon_mask_ok, mon_last_eof;
  always @(posedge clk) begin
    #1;
    if (out_valid) begin
      if (mon_cnt == 0) begin
        mon_first = cyc;  mon_mask = out_port_mask;  mon_sof_ok = out_sof;
      end else if (out_sof || out_port_mask != mon_mask) mon_mask_ok = 1'b0;
      if (mon_cnt < 256) mon_data[mon_cnt] = out_data;
      if (out_eof) mon_eofs++;
      mon_last_eof = out_eof;
      mon_abort = mon_abort | out_abort;
      mon_cnt++;
    end
  end

  task automatic mon_clear();
    mon_cnt = 0;  mon_first = 0;  mon_eofs = 0;  mon_mask = '0;
    mon_abort = 1'b0;  mon_sof_ok = 1'b0;  mon_mask_ok = 1'b1;  mon_last_eof = 1'b0;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fb(input logic [47:0] da, input logic [47:0] sa, input int i);
    if (i < 6)       return da[47-8*i -: 8];
    else if (i < 12) return sa[47-8*(i-6) -: 8];
    else             return 8'((i * 7 + 3) & 255);
  endfunction

  task automatic learn(input logic [47:0] a, input logic [1:0] p);
    @(negedge clk);
    lrn_valid = 1'b1;  lrn_addr = a;  lrn_port = p;
    @(negedge clk);
    lrn_valid = 1'b0;
  endtask

  // kind: 0 no output, 1 cut-through, 2 held
  task automatic run_frame(input logic [47:0] da, input logic [47:0] sa, input int len,
                           input logic [3:0] busy, input logic crc, input int kind,
                           input logic [3:0] emask, input logic eab, input string tag);
    int eof_c, rel;
    bit data_ok;
    @(negedge clk);
    mon_clear();
    port_busy = busy;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;  in_data = fb(da, sa, i);
      in_sof = (i == 0);  in_eof = (i == len-1);  in_crc_err = crc && (i == len-1);
      @(posedge clk);
      #1;
      if (i == len-1) eof_c = cyc;
    end
    @(negedge clk);
    in_valid = 1'b0;  in_sof = 1'b0;  in_eof = 1'b0;  in_crc_err = 1'b0;
    rel = -100;
    if (kind == 2) begin
      repeat (5) @(negedge clk);
      chk(in_ready == 1'b0, {tag, " R8 ready low while held"}, in_ready, 0);
      chk(mon_cnt == 0, {tag, " R4 silent while busy"}, mon_cnt, 0);
      port_busy = '0;
      rel = cyc;
    end
    for (int k = 0; k < 400 && !(in_ready && !out_valid); k++) @(negedge clk);
    repeat (4) @(negedge clk);
    port_busy = '0;
    chk(in_ready == 1'b1, {tag, " R8 ready after frame"}, in_ready, 1);
    if (kind == 0) begin
      chk(mon_cnt == 0, {tag, " R7/R8/R9 no output"}, mon_cnt, 0);
    end else begin
      chk(mon_cnt == len, {tag, " R5 byte count"}, mon_cnt, len);
      data_ok = 1'b1;
      for (int i = 0; i < len && i < 256; i++)
        if (mon_data[i] !== fb(da, sa, i)) data_ok = 1'b0;
      chk(data_ok, {tag, " R5 data"}, data_ok, 1);
      chk(mon_mask == emask, {tag, " R1/R2 mask"}, mon_mask, emask);
      chk(mon_sof_ok && mon_mask_ok && mon_eofs == 1 && mon_last_eof,
          {tag, " R5 framing"}, mon_eofs, 1);
      chk(mon_abort == eab, {tag, " R6 abort"}, mon_abort, eab);
      if (kind == 1)
        chk(mon_first < eof_c, {tag, " R3 cut-through early start"}, mon_first, eof_c);
      else
        chk(mon_first == rel + 2, {tag, " R4 start after release"}, mon_first, rel + 2);
    end
  endtask

  typedef struct packed {
    logic [47:0] da;
    logic [7:0]  len;
    logic [3:0]  busy;
    logic        crc;
    logic [1:0]  kind;
    logic [3:0]  mask;
    logic        abort;
  } vec_t;

  localparam logic [47:0] A1  = 48'h02_11_22_33_44_01;
  localparam logic [47:0] A2  = 48'h02_11_22_33_44_02;
  localparam logic [47:0] A3  = 48'h02_11_22_33_44_03;
  localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] UNK = 48'h02_99_88_77_66_55;
  localparam logic [47:0] SAG = 48'h03_00_00_00_00_07;
  localparam logic [47:0] LSA = 48'h02_AA_BB_CC_DD_EE;
  localparam logic [47:0] GSA = 48'h03_AA_BB_CC_DD_EF;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{A1,  8'd20, 4'b0000, 1'b0, 2'd1, 4'b0100, 1'b0},  // R1 R3 hit, cut
    '{A2,  8'd16, 4'b0001, 1'b0, 2'd1, 4'b1000, 1'b0},  // busy port outside mask
    '{BC,  8'd18, 4'b0000, 1'b0, 2'd1, 4'b1110, 1'b0},  // R2 broadcast
    '{UNK, 8'd14, 4'b0000, 1'b0, 2'd1, 4'b1110, 1'b0},  // R2 unknown floods
    '{A3,  8'd24, 4'b0010, 1'b0, 2'd2, 4'b0010, 1'b0},  // R4 held
    '{BC,  8'd15, 4'b1000, 1'b0, 2'd2, 4'b1110, 1'b0},  // R4 held flood
    '{A1,  8'd20, 4'b0000, 1'b1, 2'd1, 4'b0100, 1'b1},  // R6 late error, cut
    '{A2,  8'd22, 4'b1000, 1'b1, 2'd0, 4'b0000, 1'b0},  // R7 held, error dropped
    '{A1,  8'd64, 4'b0000, 1'b0, 2'd1, 4'b0100, 1'b0}   // long cut frame
  };

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;  nbad++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;  in_valid = 1'b0;  in_data = '0;  in_sof = 1'b0;  in_eof = 1'b0;
    in_crc_err = 1'b0;  port_busy = '0;  lrn_valid = 1'b0;  lrn_addr = '0;  lrn_port = '0;
    mon_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 reset ready", in_ready, 1);
    chk(out_valid == 1'b0 && out_port_mask == '0, "R5 reset idle", out_valid, 0);

    learn(A1, 2'd2);
    learn(A2, 2'd3);
    learn(A3, 2'd1);

    for (int v = 0; v < NV; v++)
      run_frame(VECS[v].da, SAG, int'(VECS[v].len), VECS[v].busy, VECS[v].crc,
                int'(VECS[v].kind), VECS[v].mask, VECS[v].abort, $sformatf("vec%0d", v));

    // R8 runt frame shorter than the destination address
    run_frame(BC, SAG, 4, 4'b0000, 1'b0, 0, 4'b0000, 1'b0, "runt R8");

    // R10 local learning, then R9 filtering back to the ingress port
    run_frame(BC, LSA, 16, 4'b0000, 1'b0, 1, 4'b1110, 1'b0, "learn R10");
    run_frame(LSA, SAG, 16, 4'b0000, 1'b0, 0, 4'b0000, 1'b0, "filter R9");

    // R10 group source address is not learned
    run_frame(BC, GSA, 16, 4'b0000, 1'b0, 1, 4'b1110, 1'b0, "group R10 a");
    run_frame(GSA, SAG, 16, 4'b0000, 1'b0, 1, 4'b1110, 1'b0, "group R10 b");

    // R11 rewrite of an existing entry
    learn(A1, 2'd3);
    run_frame(A1, SAG, 16, 4'b0000, 1'b0, 1, 4'b1000, 1'b0, "update R11");

    // R11 fill the table, then round-robin replacement from entry 0
    for (int k = 4; k < 8; k++) learn(48'h02_44_00_00_00_00 | 48'(k), 2'd1);
    learn(48'h02_44_00_00_00_08, 2'd2);
    run_frame(A1, SAG, 16, 4'b0000, 1'b0, 1, 4'b1110, 1'b0, "rr0 evicted R11");
    run_frame(48'h02_44_00_00_00_08, SAG, 16, 4'b0000, 1'b0, 1, 4'b0100, 1'b0, "rr0 new R11");
    learn(48'h02_44_00_00_00_09, 2'd3);
    run_frame(A2, SAG, 16, 4'b0000, 1'b0, 1, 4'b1110, 1'b0, "rr1 evicted R11");
    run_frame(A3, SAG, 16, 4'b0000, 1'b0, 1, 4'b0010, 1'b0, "rr2 kept R11");
    run_frame(48'h02_44_00_00_00_05, SAG, 16, 4'b0000, 1'b0, 1, 4'b0010, 1'b0, "fill kept R11");

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule